// File: doc/BRIEF.md
# Counter Compare and Trigger Unit

A set of compare slots that watch one shared reference counter, the counter that all synchronous PWM channels count on. Each slot holds a programmed compare value and a direction qualifier. When the counter steps onto a slot's value, the slot reports a hit. Each hit sets a sticky interrupt flag for that slot. It can also pulse one or both of two trigger lines, for example to start converter samples in step with the waveform. It can raise a DMA request strobe as well. The counter itself sits outside this block. The unit receives its value, its count direction, a center-aligned indication, a tick strobe that marks a counter step, and a strobe for the period boundary.

Compare values and direction qualifiers are double buffered. A write lands in a shadow copy. The copy in use is replaced only at the next period boundary, so a value changed while a compare is pending cannot cut a period short or fire twice. Per-slot enables, per-line slot masks and a DMA slot mask are level inputs that take effect immediately.

Top module: `pwm_cmp_event_unit`

## Requirements
- R1: While rst_ni is low, and on the first edge after release, flag_o, event_o and dma_req_o are all zero.
- R2: A slot hits in a cycle where cnt_tick_i is high, its enable is high, cnt_i equals its active compare value, and its direction qualifier allows the count. flag_o for that slot is set on the next clock edge.
- R3: A slot whose bit of unit_en_i is low never hits, and its flag is never set.
- R4: A flag stays set until its bit of irq_clr_i is high at a clock edge. If a hit and a clear arrive in the same cycle, the hit wins.
- R5: event_o[l] is high for the single cycle after a tick in which any hitting slot u has line_mask_i[l*NUM_UNITS+u] set. Otherwise it is low.
- R6: dma_req_o is high for the single cycle after a tick in which any hitting slot has its bit set in dma_mask_i.
- R7: The direction qualifier is two bits wide: bit 0 allows hits while counting up (cnt_down_i=0), and bit 1 allows hits while counting down (cnt_down_i=1). The qualifier applies only while center_mode_i is high. When center_mode_i is low, any qualifier value allows hits.
- R8: wr_en_i stores wr_val_i and wr_dir_i into the shadow copy of slot wr_sel_i. The active copy loads the shadow copy on each edge where period_start_i is high. A write made in the same cycle as period_start_i waits for the following boundary. Active copies reset to value 0 with qualifier 0.
- R9: No slot hits in a cycle where cnt_tick_i is low, even if cnt_i equals its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared reference counter value |
| cnt_tick_i | input | 1 | Counter stepped to cnt_i this cycle |
| cnt_down_i | input | 1 | Counter direction, 1 = counting down |
| center_mode_i | input | 1 | Center-aligned counting in use |
| period_start_i | input | 1 | Period boundary, loads shadow copies |
| wr_en_i | input | 1 | Shadow write strobe |
| wr_sel_i | input | SEL_W | Slot index for the write |
| wr_val_i | input | CNT_W | Compare value to write |
| wr_dir_i | input | 2 | Direction qualifier to write |
| unit_en_i | input | NUM_UNITS | Per-slot enable |
| line_mask_i | input | NUM_LINES*NUM_UNITS | Per-line slot masks, line l in bits l*NUM_UNITS upward |
| dma_mask_i | input | NUM_UNITS | Slots that raise the DMA request |
| irq_clr_i | input | NUM_UNITS | Per-slot flag clear |
| flag_o | output | NUM_UNITS | Sticky interrupt flags |
| event_o | output | NUM_LINES | Trigger line pulses |
| dma_req_o | output | 1 | DMA request strobe |

## Verification
Every result is due exactly one edge after the cycle that caused it. A hit, a clear, a mask change or a period load seen at edge k shows up on flag_o, event_o, dma_req_o or the compare behaviour just after edge k. The bench sets inputs one nanosecond after an edge and predicts the outputs from its own model of shadow and active copies. It then waits for the next edge and compares all outputs one nanosecond after it. That way each prediction lines up with the single register stage between input and output. Period loads are modelled from the old shadow contents, so a write that coincides with a boundary is predicted to wait a full period.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10,
    DIR_BOTH = 2'b11
  } match_dir_e;
endpackage

// File: rtl/pwm_cmp_slot.sv
module pwm_cmp_slot #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned IDX   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic [1:0]       wr_dir_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_tick_i,
  input  logic             cnt_down_i,
  input  logic             center_mode_i,
  input  logic             en_i,
  output logic             hit_o
);
  import pwm_cmp_pkg::*;

  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

  logic [CNT_W-1:0] sh_val_q, ac_val_q;
  match_dir_e       sh_dir_q, ac_dir_q;
  logic             dir_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_val_q <= '0;
      sh_dir_q <= DIR_NONE;
    end else if (wr_en_i && wr_sel_i == MY_SEL) begin
      sh_val_q <= wr_val_i;
      sh_dir_q <= match_dir_e'(wr_dir_i);
    end
  end

  // active copy takes the pre-write shadow at a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_val_q <= '0;
      ac_dir_q <= DIR_NONE;
    end else if (load_i) begin
      ac_val_q <= sh_val_q;
      ac_dir_q <= sh_dir_q;
    end
  end

  always_comb begin
    if (!center_mode_i) dir_ok = 1'b1;
    else if (cnt_down_i) dir_ok = ac_dir_q[1];
    else                 dir_ok = ac_dir_q[0];
  end

  assign hit_o = cnt_tick_i && en_i && dir_ok && (cnt_i == ac_val_q);
endmodule

// File: rtl/pwm_cmp_router.sv
module pwm_cmp_router #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned NUM_LINES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_UNITS-1:0]           hit_i,
  input  logic [NUM_LINES*NUM_UNITS-1:0] line_mask_i,
  input  logic [NUM_UNITS-1:0]           dma_mask_i,
  output logic [NUM_LINES-1:0]           event_o,
  output logic                           dma_req_o
);
  logic [NUM_LINES-1:0] event_d;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign event_d[l] = |(hit_i & line_mask_i[l*NUM_UNITS +: NUM_UNITS]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event_o   <= '0;
      dma_req_o <= 1'b0;
    end else begin
      event_o   <= event_d;
      dma_req_o <= |(hit_i & dma_mask_i);
    end
  end
endmodule

// File: rtl/pwm_cmp_flags.sv
module pwm_cmp_flags #(
  parameter int unsigned NUM_UNITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_UNITS-1:0] hit_i,
  input  logic [NUM_UNITS-1:0] clr_i,
  output logic [NUM_UNITS-1:0] flag_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | hit_i;
  end
endmodule

// File: rtl/pwm_cmp_event_unit.sv
module pwm_cmp_event_unit #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned NUM_LINES = 2,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned SEL_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic                           cnt_tick_i,
  input  logic                           cnt_down_i,
  input  logic                           center_mode_i,
  input  logic                           period_start_i,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [CNT_W-1:0]               wr_val_i,
  input  logic [1:0]                     wr_dir_i,
  input  logic [NUM_UNITS-1:0]           unit_en_i,
  input  logic [NUM_LINES*NUM_UNITS-1:0] line_mask_i,
  input  logic [NUM_UNITS-1:0]           dma_mask_i,
  input  logic [NUM_UNITS-1:0]           irq_clr_i,
  output logic [NUM_UNITS-1:0]           flag_o,
  output logic [NUM_LINES-1:0]           event_o,
  output logic                           dma_req_o
);
  logic [NUM_UNITS-1:0] hit_w;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
    pwm_cmp_slot #(
      .CNT_W (CNT_W),
      .SEL_W (SEL_W),
      .IDX   (u)
    ) slot_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_en_i       (wr_en_i),
      .wr_sel_i      (wr_sel_i),
      .wr_val_i      (wr_val_i),
      .wr_dir_i      (wr_dir_i),
      .load_i        (period_start_i),
      .cnt_i         (cnt_i),
      .cnt_tick_i    (cnt_tick_i),
      .cnt_down_i    (cnt_down_i),
      .center_mode_i (center_mode_i),
      .en_i          (unit_en_i[u]),
      .hit_o         (hit_w[u])
    );
  end

  pwm_cmp_router #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_LINES (NUM_LINES)
  ) router_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit_w),
    .line_mask_i (line_mask_i),
    .dma_mask_i  (dma_mask_i),
    .event_o     (event_o),
    .dma_req_o   (dma_req_o)
  );

  pwm_cmp_flags #(
    .NUM_UNITS (NUM_UNITS)
  ) flags_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_w),
    .clr_i  (irq_clr_i),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/pwm_cmp_event_chk.sv
module pwm_cmp_event_chk #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned NUM_LINES = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cnt_tick_i,
  input logic [NUM_UNITS-1:0] unit_en_i,
  input logic [NUM_UNITS-1:0] dma_mask_i,
  input logic [NUM_UNITS-1:0] irq_clr_i,
  input logic [NUM_UNITS-1:0] hit_i,
  input logic [NUM_UNITS-1:0] flag_o,
  input logic [NUM_LINES-1:0] event_o,
  input logic                 dma_req_o
);
  a_r3_disabled_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(unit_en_i)) == '0));

  a_r9_no_flag_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_tick_i |=> ((flag_o & ~$past(flag_o)) == '0));

  a_r4_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_o & irq_clr_i & ~hit_i) & flag_o) == '0));

  a_r5_event_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_o) |-> $past(cnt_tick_i));

  a_r6_dma_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> ($past(cnt_tick_i) && $past(|dma_mask_i)));

  a_r2_flag_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((flag_o & $past(hit_i)) == $past(hit_i)));
endmodule

bind pwm_cmp_event_unit pwm_cmp_event_chk #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_LINES (NUM_LINES)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_tick_i (cnt_tick_i),
  .unit_en_i  (unit_en_i),
  .dma_mask_i (dma_mask_i),
  .irq_clr_i  (irq_clr_i),
  .hit_i      (hit_w),
  .flag_o     (flag_o),
  .event_o    (event_o),
  .dma_req_o  (dma_req_o)
);

// File: tb/pwm_cmp_event_unit_tb.sv
`timescale 1ns/1ps
module pwm_cmp_event_unit_tb_top;
  localparam int N = 8;
  localparam int L = 2;
  localparam int W = 16;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [W-1:0]   cnt_i = '0;
  logic           cnt_tick_i = 1'b0;
  logic           cnt_down_i = 1'b0;
  logic           center_mode_i = 1'b0;
  logic           period_start_i = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [2:0]     wr_sel_i = '0;
  logic [W-1:0]   wr_val_i = '0;
  logic [1:0]     wr_dir_i = '0;
  logic [N-1:0]   unit_en_i = '0;
  logic [L*N-1:0] line_mask_i = '0;
  logic [N-1:0]   dma_mask_i = '0;
  logic [N-1:0]   irq_clr_i = '0;
  logic [N-1:0]   flag_o;
  logic [L-1:0]   event_o;
  logic           dma_req_o;

  always #5 clk_i = ~clk_i;

  pwm_cmp_event_unit #(.NUM_UNITS(N), .NUM_LINES(L), .CNT_W(W)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] sh_val [N];
  logic [W-1:0] ac_val [N];
  logic [1:0]   sh_dir [N];
  logic [1:0]   ac_dir [N];
  logic [N-1:0] exp_flag;
  logic [L-1:0] exp_evt;
  logic         exp_dma;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: predict from current inputs, clock, compare, clear strobes
  task automatic step(input string tag);
    logic [N-1:0] hit;
    logic         dok;
    for (int u = 0; u < N; u++) begin
      dok = !center_mode_i || (cnt_down_i ? ac_dir[u][1] : ac_dir[u][0]);
      hit[u] = cnt_tick_i && unit_en_i[u] && dok && (cnt_i == ac_val[u]);
    end
    @(posedge clk_i);
    #1;
    exp_flag = (exp_flag & ~irq_clr_i) | hit;
    for (int l = 0; l < L; l++) exp_evt[l] = |(hit & line_mask_i[l*N +: N]);
    exp_dma = |(hit & dma_mask_i);
    if (period_start_i)
      for (int u = 0; u < N; u++) begin
        ac_val[u] = sh_val[u];
        ac_dir[u] = sh_dir[u];
      end
    if (wr_en_i) begin
      sh_val[wr_sel_i] = wr_val_i;
      sh_dir[wr_sel_i] = wr_dir_i;
    end
    chk({tag, " flags"}, 32'(flag_o), 32'(exp_flag));
    chk({tag, " events R5"}, 32'(event_o), 32'(exp_evt));
    chk({tag, " dma R6"}, 32'(dma_req_o), 32'(exp_dma));
    wr_en_i = 1'b0;
    period_start_i = 1'b0;
    irq_clr_i = '0;
    cnt_tick_i = 1'b0;
  endtask

  task automatic write_slot(input int u, input int v, input logic [1:0] d, input string tag);
    wr_en_i = 1'b1;
    wr_sel_i = 3'(u);
    wr_val_i = W'(v);
    wr_dir_i = d;
    step(tag);
  endtask

  task automatic boundary(input string tag);
    period_start_i = 1'b1;
    step(tag);
  endtask

  task automatic sweep(input int lo, input int hi, input logic down, input string tag);
    for (int i = 0; i <= hi - lo; i++) begin
      cnt_i = W'(down ? hi - i : lo + i);
      cnt_down_i = down;
      cnt_tick_i = 1'b1;
      step(tag);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int u = 0; u < N; u++) begin
      sh_val[u] = '0; ac_val[u] = '0; sh_dir[u] = '0; ac_dir[u] = '0;
    end
    exp_flag = '0; exp_evt = '0; exp_dma = 1'b0;
    #12;
    chk("R1 reset flags", 32'(flag_o), 0);
    chk("R1 reset events", 32'(event_o), 0);
    chk("R1 reset dma", 32'(dma_req_o), 0);
    rst_ni = 1'b1;
    #4;
    step("R1 first edge");

    // R8: program shadows, load at boundary
    for (int u = 0; u < N; u++) write_slot(u, u * 3 + 2, 2'(u % 4), "R8 write");
    sweep(0, 31, 1'b0, "R8 before load");
    boundary("R8 load");

    // R2 R5 R6 left-aligned, qualifier ignored (R7)
    unit_en_i = 8'hFF;
    line_mask_i = {8'hA5, 8'h0F};
    dma_mask_i = 8'h3C;
    sweep(0, 31, 1'b0, "R2 left up");
    irq_clr_i = 8'hFF; step("R4 clear all");
    sweep(0, 31, 1'b1, "R7 left ignores dir");
    irq_clr_i = 8'hFF; step("R4 clear all");

    // R7 center-aligned up then down
    center_mode_i = 1'b1;
    sweep(0, 31, 1'b0, "R7 center up");
    irq_clr_i = 8'h0F; step("R4 partial clear");
    sweep(0, 31, 1'b1, "R7 center down");
    irq_clr_i = 8'hFF; step("R4 clear all");
    center_mode_i = 1'b0;

    // R3 disabled slots
    unit_en_i = 8'h55;
    sweep(0, 31, 1'b0, "R3 half enabled");
    unit_en_i = 8'h00;
    irq_clr_i = 8'hFF; step("R4 clear all");
    sweep(0, 31, 1'b0, "R3 none enabled");
    unit_en_i = 8'hFF;

    // R9 counter on a value with no tick
    for (int c = 0; c < 32; c++) begin
      cnt_i = W'(c);
      step("R9 no tick");
    end

    // R4 set beats clear
    cnt_i = W'(2); cnt_tick_i = 1'b1; irq_clr_i = 8'h01;
    step("R4 set wins");
    irq_clr_i = 8'h01; step("R4 clear slot0");

    // R8 write while pending keeps old value this period
    write_slot(0, 40, 2'b11, "R8 pending write");
    sweep(0, 47, 1'b0, "R8 old value in use");
    boundary("R8 load new");
    irq_clr_i = 8'hFF; step("R4 clear all");
    sweep(0, 47, 1'b0, "R8 new value in use");
    // write coinciding with boundary waits another period
    wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_val_i = W'(44); wr_dir_i = 2'b11;
    period_start_i = 1'b1;
    step("R8 write at boundary");
    sweep(0, 47, 1'b0, "R8 coincident deferred");
    boundary("R8 second load");
    sweep(0, 47, 1'b0, "R8 coincident applied");

    // mask patterns across lines and DMA
    for (int m = 0; m < 8; m++) begin
      line_mask_i = {8'(1 << m), 8'(~(1 << m))};
      dma_mask_i = 8'(1 << ((m + 3) % 8));
      sweep(0, 47, 1'b0, "R5 R6 mask walk");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule